// File: doc/BRIEF.md
# Key-Guarded Word Store Write Controller

This block protects a small word-wide nonvolatile data store from accidental modification. Software reaches it through a plain register bus that has a write strobe, a 3-bit register select, a 16-bit write word and a combinational read word. Before it may start a program or erase, software must write two fixed values, in order, to a write-only key register. That sequence opens a window for the control register that lasts exactly one cycle. A start bit written to the control register in that cycle launches the selected operation. The operation works on a behavioural array of 16-bit words.

A cycle counter stands in for the cell timing. The start bit stays high while the operation runs and then clears itself. A done flag or an error flag reports the result. The bus has no ready signal and never waits. Register reads and writes to other registers go on normally while an operation is in flight, because the operation works on a snapshot of the address and the data taken when it starts. The block has no streaming interface, so back-pressure does not apply: every bus access completes in the cycle it is presented.

Top module: `nvm_keyguard`

## Requirements
- R1: Reading the key register (select 0) returns 0x0000 at all times, including right after key writes.
- R2: The unlock opens only when 0x0055 and then 0x00AA are written to the key register. Bus cycles without a write may fall between them. Any other bus write between them, or a wrong key value, returns the sequence to idle.
- R3: A control write (select 3) takes effect only in the bus cycle directly after the 0x00AA key write. At any other time it is ignored, and the control readback and the array stay unchanged.
- R4: The array holds WORDS (default 256) 16-bit words. The byte address is {addr_hi[7:0], addr_lo[15:0]} (selects 2 and 1). Bits [8:1] pick the word and bit 0 is ignored. The valid range is 0x7FFE00 to 0x7FFFFF. Select 5 reads the word picked by bits [8:1].
- R5: Control layout: bit 15 is start/busy, bit 14 is done, bit 13 is error, and bits [7:0] are the operation code (0x01 program word, 0x02 erase word). An accepted control write loads the code and clears done and error.
- R6: After a valid start, bit 15 reads 1 for exactly PROG_CYCLES cycles. It then clears, and done reads 1.
- R7: A program writes the staged data word (select 4) into the addressed word. An erase sets the addressed word to 0xFFFF.
- R8: A start with an address outside the range, or with an operation code other than 0x01 or 0x02, sets error, never sets busy, and leaves the array unchanged.
- R9: Changing the address or the staged data while busy does not affect the operation in flight.
- R10: After reset, all registers read 0 and every array word reads 0xFFFF.
- R11: A correctly unlocked control write made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_sel | input | 3 | Register select: 0 key, 1 address low, 2 address high, 3 control, 4 staged data, 5 array peek |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data of the selected register |

## Verification
The bench programs all 256 words with an arithmetic pattern, reading each one back through the peek register. It also erases every third word, so any slip in the address bits or the data path shows up as a wrong word. It sweeps every unsupported operation code and several addresses just outside the window on both sides, which separates a correct range and code check from a loose one. Key sequences are tried in the wrong order, with a stray write in the middle, with a wrong second value, with an idle cycle between unlock and control, and with an idle cycle inside the key pair. This tells a one-cycle window apart from a sticky or missing one. A second start and address changes made during a busy period confirm the snapshot and the fixed busy length.

// File: rtl/nvm_kg_pkg.sv
package nvm_kg_pkg;
  localparam logic [2:0] SEL_KEY  = 3'd0;
  localparam logic [2:0] SEL_ALO  = 3'd1;
  localparam logic [2:0] SEL_AHI  = 3'd2;
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_DATA = 3'd4;
  localparam logic [2:0] SEL_PEEK = 3'd5;

  localparam logic [15:0] KEY_FIRST  = 16'h0055;
  localparam logic [15:0] KEY_SECOND = 16'h00AA;

  localparam logic [7:0] OP_PROG  = 8'h01;
  localparam logic [7:0] OP_ERASE = 8'h02;

  localparam int B_START = 15;
  localparam int B_DONE  = 14;
  localparam int B_ERR   = 13;

  localparam int ABW = 24;
  localparam logic [ABW-1:0] WIN_TOP = 24'h800000;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} ul_state_e;

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_PROG) || (op == OP_ERASE);
  endfunction
endpackage

// File: rtl/nvm_kg_unlock.sv
module nvm_kg_unlock
  import nvm_kg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [2:0]  sel,
  input  logic [15:0] wdata,
  output logic        win_open
);
  ul_state_e state, nxt;
  logic key1, key2;

  assign key1 = wr && (sel == SEL_KEY) && (wdata == KEY_FIRST);
  assign key2 = wr && (sel == SEL_KEY) && (wdata == KEY_SECOND);

  always_comb begin
    nxt = state;
    if (wr) begin
      case (state)
        UL_IDLE: nxt = key1 ? UL_HALF : UL_IDLE;
        UL_HALF: nxt = key2 ? UL_OPEN : UL_IDLE;
        UL_OPEN: nxt = key1 ? UL_HALF : UL_IDLE;
        default: nxt = UL_IDLE;
      endcase
    end else if (state == UL_OPEN) begin
      nxt = UL_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= UL_IDLE;
    else        state <= nxt;
  end

  assign win_open = (state == UL_OPEN);

  AST_WIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |=> !win_open); // R3
  AST_WIN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> $past(wr && sel == SEL_KEY && wdata == KEY_SECOND)); // R2
endmodule

// File: rtl/nvm_kg_seq.sv
module nvm_kg_seq
  import nvm_kg_pkg::*;
#(
  parameter int PROG_CYCLES = 8,
  parameter int IW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          ctl_start,
  input  logic [7:0]    ctl_op,
  input  logic          in_range,
  input  logic [IW-1:0] idx_in,
  input  logic [DW-1:0] data_in,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [7:0]    op,
  output logic          mem_we,
  output logic [IW-1:0] mem_idx,
  output logic [DW-1:0] mem_data
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  logic [CW-1:0] cnt;
  logic accept;

  assign accept = ctl_we && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; err <= 1'b0; op <= '0;
      cnt <= '0; mem_idx <= '0; mem_data <= '0;
    end else if (accept) begin
      op   <= ctl_op;
      done <= 1'b0;
      err  <= 1'b0;
      if (ctl_start) begin
        if (!in_range || !op_known(ctl_op)) begin
          err <= 1'b1;
        end else begin
          busy     <= 1'b1;
          cnt      <= CW'(PROG_CYCLES - 1);
          mem_idx  <= idx_in;
          mem_data <= (ctl_op == OP_ERASE) ? {DW{1'b1}} : data_in;
        end
      end
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign mem_we = busy && (cnt == '0);

  AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !err); // R8
  AST_WE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!busy && done)); // R6
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctl_we && ctl_start)); // R5
endmodule

// File: rtl/nvm_kg_array.sv
module nvm_kg_array #(
  parameter int WORDS = 256,
  parameter int DW = 16,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= {DW{1'b1}};
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/nvm_keyguard.sv
module nvm_keyguard
  import nvm_kg_pkg::*;
#(
  parameter int PROG_CYCLES = 8,
  parameter int WORDS = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_sel,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata
);
  localparam int DW = 16;
  localparam int IW = $clog2(WORDS);
  localparam logic [ABW-1:0] WIN_BASE = WIN_TOP - ABW'(2 * WORDS);

  logic [15:0] addr_lo;
  logic [7:0]  addr_hi;
  logic [DW-1:0] stage;
  logic [ABW-1:0] baddr;
  logic [IW-1:0] idx;
  logic in_range, win_open, ctl_we;
  logic busy, done, err, mem_we;
  logic [7:0] op;
  logic [IW-1:0] mem_idx;
  logic [DW-1:0] mem_data, peek;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lo <= '0; addr_hi <= '0; stage <= '0;
    end else if (bus_wr) begin
      case (bus_sel)
        SEL_ALO:  addr_lo <= bus_wdata;
        SEL_AHI:  addr_hi <= bus_wdata[7:0];
        SEL_DATA: stage   <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign baddr    = {addr_hi, addr_lo};
  assign idx      = baddr[IW:1];
  assign in_range = (baddr[ABW-1:IW+1] == WIN_BASE[ABW-1:IW+1]);
  assign ctl_we   = bus_wr && (bus_sel == SEL_CTRL) && win_open;

  nvm_kg_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(bus_sel),
    .wdata(bus_wdata), .win_open(win_open)
  );

  nvm_kg_seq #(.PROG_CYCLES(PROG_CYCLES), .IW(IW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we),
    .ctl_start(bus_wdata[B_START]), .ctl_op(bus_wdata[7:0]),
    .in_range(in_range), .idx_in(idx), .data_in(stage),
    .busy(busy), .done(done), .err(err), .op(op),
    .mem_we(mem_we), .mem_idx(mem_idx), .mem_data(mem_data)
  );

  nvm_kg_array #(.WORDS(WORDS), .DW(DW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .widx(mem_idx),
    .wdata(mem_data), .ridx(idx), .rdata(peek)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_sel)
      SEL_ALO:  bus_rdata = addr_lo;
      SEL_AHI:  bus_rdata = {8'h00, addr_hi};
      SEL_CTRL: begin
        bus_rdata         = {8'h00, op};
        bus_rdata[B_START] = busy;
        bus_rdata[B_DONE]  = done;
        bus_rdata[B_ERR]   = err;
      end
      SEL_DATA: bus_rdata = stage;
      SEL_PEEK: bus_rdata = peek;
      default:  bus_rdata = '0;
    endcase
  end

  AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == SEL_CTRL && !win_open) |=> $stable(op)); // R3
  AST_NO_WRITE_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !busy && !in_range) |=> !busy); // R8
endmodule

// File: tb/tb_nvm_keyguard.sv
module tb_nvm_keyguard;
  localparam int CYC = 8;
  localparam int WORDS = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [2:0] bus_sel = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;

  int checks = 0;
  int fails = 0;
  bit reported = 0;
  logic [15:0] model [WORDS];

  always #2 clk = ~clk;

  nvm_keyguard #(.PROG_CYCLES(CYC), .WORDS(WORDS)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: act=timeout exp=finish");
    report();
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [2:0] s, input logic [15:0] d);
    bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [15:0] v);
    bus_sel = s; #1; v = bus_rdata;
  endtask

  task automatic setaddr(input logic [23:0] a);
    bw(3'd1, a[15:0]); bw(3'd2, {8'h00, a[23:16]});
  endtask

  task automatic unlock();
    bw(3'd0, 16'h0055); bw(3'd0, 16'h00AA);
  endtask

  task automatic wait_idle(output int n);
    logic [15:0] v;
    n = 0;
    rd(3'd3, v);
    while (v[15] && n < 1000) begin
      n++; @(negedge clk); rd(3'd3, v);
    end
  endtask

  function automatic bit in_win(input logic [23:0] a);
    return a >= 24'h7FFE00 && a <= 24'h7FFFFF;
  endfunction

  task automatic run_op(input logic [23:0] a, input logic [15:0] d, input logic [7:0] op, output int n);
    setaddr(a); bw(3'd4, d); unlock(); bw(3'd3, {8'h80, op});
    wait_idle(n);
    if (in_win(a) && (op == 8'h01 || op == 8'h02))
      model[a[8:1]] = (op == 8'h02) ? 16'hFFFF : d;
  endtask

  task automatic peek_chk(input string req, input logic [23:0] a);
    logic [15:0] v;
    setaddr(a); rd(3'd5, v); chk(req, v, model[a[8:1]]);
  endtask

  initial begin
    logic [15:0] v;
    int n;
    logic [23:0] a;
    for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(3'd3, v); chk("R10 ctrl", v, 16'h0000);
    rd(3'd1, v); chk("R10 addr_lo", v, 16'h0000);
    rd(3'd4, v); chk("R10 stage", v, 16'h0000);
    rd(3'd5, v); chk("R10 word0", v, 16'hFFFF);

    // R7 R4 R6 program every word, odd byte bit on odd words
    for (int i = 0; i < WORDS; i++) begin
      a = 24'h7FFE00 + 24'(2 * i) + 24'(i & 1);
      run_op(a, 16'(i * 16'h0101) ^ 16'h5A3C, 8'h01, n);
      rd(3'd3, v); chk("R6 done", v, 16'h4001);
      if (i == 5) chk("R6 busy length", 16'(n), 16'(CYC));
    end
    for (int i = 0; i < WORDS; i++) peek_chk("R7 R4 program readback", 24'h7FFE00 + 24'(2 * i));

    // R7 erase every third word
    for (int i = 0; i < WORDS; i += 3) begin
      run_op(24'h7FFE00 + 24'(2 * i), 16'h1234, 8'h02, n);
      rd(3'd3, v); chk("R7 erase done", v, 16'h4002);
    end
    for (int i = 0; i < WORDS; i++) peek_chk("R7 erase readback", 24'h7FFE00 + 24'(2 * i));

    // R1 key reads zero
    bw(3'd0, 16'h0055); rd(3'd0, v); chk("R1 key read", v, 16'h0000);
    bw(3'd0, 16'h00AA); rd(3'd0, v); chk("R1 key read", v, 16'h0000);

    // R8 out-of-range addresses
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: a = 24'h7FFDFE;
        1: a = 24'h800000;
        2: a = 24'h000002;
        default: a = 24'hFFFE10;
      endcase
      run_op(a, 16'hBEEF, 8'h01, n);
      chk("R8 no busy", 16'(n), 16'd0);
      rd(3'd3, v); chk("R8 range err", v, 16'h2001);
      peek_chk("R8 array unchanged", a);
    end

    // R8 unsupported codes
    for (int c = 0; c < 256; c++) begin
      if (c == 1 || c == 2) continue;
      run_op(24'h7FFE10, 16'hDEAD, 8'(c), n);
      rd(3'd3, v); chk("R8 bad op err", v, 16'h2000 | 16'(c));
    end
    peek_chk("R8 bad op unchanged", 24'h7FFE10);

    // R3 R5 accepted write without start loads op 0 and clears flags
    unlock(); bw(3'd3, 16'h0000);
    rd(3'd3, v); chk("R5 clear", v, 16'h0000);
    setaddr(24'h7FFE20); bw(3'd4, 16'h7777);
    for (int k = 0; k < 5; k++) begin
      case (k)
        0: ;
        1: begin bw(3'd0, 16'h00AA); bw(3'd0, 16'h0055); end
        2: begin bw(3'd0, 16'h0055); bw(3'd1, 16'hFE20); bw(3'd0, 16'h00AA); end
        3: begin bw(3'd0, 16'h0055); bw(3'd0, 16'h0056); bw(3'd0, 16'h00AA); end
        default: begin unlock(); @(negedge clk); end
      endcase
      bw(3'd3, 16'h8001);
      repeat (CYC + 2) @(negedge clk);
      rd(3'd3, v); chk("R3 R2 ctrl ignored", v, 16'h0000);
      rd(3'd5, v); chk("R3 array unchanged", v, model[8'h10]);
    end

    // R2 idle cycle inside key pair is tolerated
    bw(3'd0, 16'h0055); @(negedge clk); bw(3'd0, 16'h00AA); bw(3'd3, 16'h8001);
    rd(3'd3, v); chk("R2 gap accepted", v, 16'h8001);
    wait_idle(n);
    model[8'h10] = 16'h7777;
    rd(3'd5, v); chk("R2 program", v, 16'h7777);

    // R9 R11 changes during busy
    setaddr(24'h7FFE40); bw(3'd4, 16'hA5A5);
    unlock(); bw(3'd3, 16'h8001);
    n = 1;
    setaddr(24'h7FFE42); n += 2;
    bw(3'd4, 16'h0F0F); n += 1;
    unlock(); bw(3'd3, 16'h8002); n += 3;
    rd(3'd3, v); chk("R11 still busy op", v, 16'h8001);
    begin
      int m;
      wait_idle(m);
      chk("R11 busy length", 16'(n - 1 + m), 16'(CYC));
    end
    model[8'h20] = 16'hA5A5;
    peek_chk("R9 snapshot target", 24'h7FFE40);
    peek_chk("R9 R11 other word", 24'h7FFE42);
    rd(3'd4, v); chk("R9 stage reg", v, 16'h0F0F);

    report();
    $finish;
  end
endmodule